// File: doc/BRIEF.md
# Oversampling Serial Receiver with Break and Address Handling

The block receives asynchronous serial frames on a single line. It samples the line sixteen times per bit and takes each bit at its centre. It can be set to 8-bit words with no parity, 8-bit words with even or odd parity, or 9-bit words, followed by one or two stop bits. Each finished word goes into a four-entry receive queue together with its framing error, parity error and address tag. The consumer reads the head word and pops it with a single-cycle read strobe.

A line that stays low for a whole frame is treated as a break. The block stores it as an all-zero word with the framing error set. It then refuses to look for a new start bit until the line has gone high again. In 9-bit multidrop use, words whose ninth bit is set are tagged as addresses, and each one raises an interrupt. A loopback select feeds the local transmit line into the receiver in place of the receive pin. The block contains its own 16-bit baud divider.

Top module: `urx_top`

## Requirements
- R1: A bit lasts 16 × (cfg_div + 1) clock cycles. Frames sent at that rate are received correctly for cfg_div = 0 and cfg_div = 2.
- R2: With cfg_fmt = 0 (8 bits, no parity), eight data bits are taken least significant bit first into rd_data[7:0], and rd_data[8] reads 0.
- R3: With cfg_fmt = 1 (even) or cfg_fmt = 2 (odd), a parity bit follows the 8 data bits. rd_perr is 1 exactly when the total count of ones in the data and parity bits is odd (for even) or even (for odd). With cfg_fmt = 0 or 3, rd_perr is always 0.
- R4: With cfg_fmt = 3, nine data bits are received least significant bit first into rd_data[8:0].
- R5: cfg_two_stop = 1 selects two stop bits. rd_ferr is 1 if any configured stop-bit sample is 0.
- R6: rx_idle falls when a start edge is detected and stays 0 until the centre sample of the last stop bit. It is 1 from then until the next start edge.
- R7: If the line is high again at the centre of a start bit, no word is stored and the receiver returns to waiting with rx_idle = 1.
- R8: A frame whose data, parity and first stop samples are all 0 is a break. It is stored as rd_data = 0 with rd_ferr = 1 and rd_perr = 0. After any framing error, no start bit is accepted until the line has been seen high, so a continuing low level stores no further word.
- R9: The queue holds 4 words and shows its oldest word on the rd_* outputs. data_avail is 1 while the queue is non-empty, and a rd_en pulse removes the head word.
- R10: A word that completes while the queue is full is discarded and sets overrun. overrun stays set until ovr_clr is pulsed.
- R11: irq pulses for one cycle when a word is stored and the queue already held at least cfg_irq_thr words.
- R12: With cfg_addr_en = 1 and cfg_fmt = 3, rd_is_addr equals the word's ninth bit, and irq pulses for every stored address word and for no data word, whatever cfg_irq_thr is. In other formats rd_is_addr is 0.
- R13: With cfg_loop = 1, the receiver takes tx_loop instead of rx_pin, and activity on rx_pin has no effect.
- R14: Reset empties the queue and clears overrun. After reset, rx_idle = 1, data_avail = 0, irq = 0 and rd_data = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 16 | Baud divider value; a tick occurs every cfg_div + 1 cycles |
| cfg_fmt | input | 2 | Word format: 0 = 8 bits no parity, 1 = 8 bits even parity, 2 = 8 bits odd parity, 3 = 9 bits |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_addr_en | input | 1 | Enables address tagging in 9-bit format |
| cfg_loop | input | 1 | 1 routes tx_loop into the receiver |
| cfg_irq_thr | input | 2 | Queue occupancy at which a stored word raises irq |
| rx_pin | input | 1 | Serial receive line |
| tx_loop | input | 1 | Local transmit line for loopback |
| rd_en | input | 1 | Pops the head word |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 9 | Head word data |
| rd_ferr | output | 1 | Head word framing error |
| rd_perr | output | 1 | Head word parity error |
| rd_is_addr | output | 1 | Head word is an address |
| data_avail | output | 1 | Queue not empty |
| rx_idle | output | 1 | Receiver idle status |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The checks assume that rd_en is asserted only as a short pulse and that software does not count on a pop and a store in the same cycle to give a particular irq decision. They also assume that cfg_irq_thr stays below the queue depth and that the format, stop and divider settings change only while the line rests high between frames. The stimulus follows these rules: it changes configuration only after a frame and its idle gap, and it pulses rd_en and ovr_clr for one cycle at a falling clock edge. It drives every serial bit for exactly 16 × (cfg_div + 1) cycles.

// File: rtl/urx_pkg.sv
package urx_pkg;
   // word format codes; the encoding is visible on the cfg_fmt port
   typedef enum logic [1:0] {
      FMT_8N = 2'd0,
      FMT_8E = 2'd1,
      FMT_8O = 2'd2,
      FMT_9N = 2'd3
   } urx_fmt_e;

   typedef enum logic [2:0] {
      RS_IDLE,
      RS_START,
      RS_BITS,
      RS_STOP,
      RS_HOLD
   } urx_state_e;

   localparam int unsigned WORD_W = 9;

   typedef struct packed {
      logic              is_addr;
      logic              ferr;
      logic              perr;
      logic [WORD_W-1:0] data;
   } urx_entry_t;
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("urx_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= RST_VAL;
         else        q_r <= d;
      end
      assign q = q_r;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/urx_baud.sv
module urx_baud #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   if (DIV_W < 1 || DIV_W > 32) begin : g_bad_width
      $error("urx_baud: DIV_W out of range");
   end

   logic [DIV_W-1:0] cnt;

   assign tick = (cnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + DIV_W'(1);
   end
endmodule

// File: rtl/urx_frame.sv
module urx_frame
   import urx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd,
   input  logic [1:0] fmt,
   input  logic       two_stop,
   input  logic       addr_en,
   output logic       out_valid,
   output urx_entry_t out_entry,
   output logic       idle
);
   localparam logic [3:0] MID_START = 4'd7;
   localparam logic [3:0] MID_BIT   = 4'd15;

   urx_state_e        st;
   urx_fmt_e          fmt_e;
   logic [3:0]        tcnt;
   logic [3:0]        bitn;
   logic [3:0]        last_bit;
   logic [WORD_W-1:0] sh;
   logic [WORD_W-1:0] word_d;
   logic              second;
   logic              first_low;
   logic              any_one;
   logic              brk;
   logic              par_bad;
   logic              ferr_now;
   logic              addr_now;

   assign fmt_e    = urx_fmt_e'(fmt);
   assign last_bit = (fmt_e == FMT_8N) ? 4'd7 : 4'd8;
   assign idle     = (st == RS_IDLE) || (st == RS_HOLD);

   // word assembly at the end of the frame, using the live stop sample
   always_comb begin
      case (fmt_e)
         FMT_8N:         word_d = {1'b0, sh[8:1]};
         FMT_8E, FMT_8O: word_d = {1'b0, sh[7:0]};
         default:        word_d = sh;
      endcase
      brk      = !any_one && (second ? first_low : !rxd);
      ferr_now = (second && first_low) || !rxd;
      par_bad  = ((fmt_e == FMT_8E) && (^sh)) || ((fmt_e == FMT_8O) && !(^sh));
      if (brk) par_bad = 1'b0;
      addr_now = addr_en && (fmt_e == FMT_9N) && sh[8];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RS_IDLE;
         tcnt      <= '0;
         bitn      <= '0;
         sh        <= '0;
         second    <= 1'b0;
         first_low <= 1'b0;
         any_one   <= 1'b0;
         out_valid <= 1'b0;
         out_entry <= '0;
      end else begin
         out_valid <= 1'b0;
         case (st)
            RS_IDLE: begin
               if (tick && !rxd) begin
                  st   <= RS_START;
                  tcnt <= '0;
               end
            end
            RS_START: begin
               if (tick) begin
                  if (tcnt == MID_START) begin
                     tcnt <= '0;
                     if (rxd) begin
                        st <= RS_IDLE;
                     end else begin
                        st      <= RS_BITS;
                        bitn    <= '0;
                        sh      <= '0;
                        any_one <= 1'b0;
                     end
                  end else begin
                     tcnt <= tcnt + 4'd1;
                  end
               end
            end
            RS_BITS: begin
               if (tick) begin
                  tcnt <= tcnt + 4'd1;
                  if (tcnt == MID_BIT) begin
                     sh      <= {rxd, sh[WORD_W-1:1]};
                     any_one <= any_one | rxd;
                     bitn    <= bitn + 4'd1;
                     if (bitn == last_bit) begin
                        st     <= RS_STOP;
                        second <= 1'b0;
                     end
                  end
               end
            end
            RS_STOP: begin
               if (tick) begin
                  tcnt <= tcnt + 4'd1;
                  if (tcnt == MID_BIT) begin
                     if (two_stop && !second) begin
                        second    <= 1'b1;
                        first_low <= !rxd;
                     end else begin
                        out_valid         <= 1'b1;
                        out_entry.data    <= brk ? '0 : word_d;
                        out_entry.ferr    <= ferr_now;
                        out_entry.perr    <= par_bad;
                        out_entry.is_addr <= addr_now;
                        st                <= ferr_now ? RS_HOLD : RS_IDLE;
                     end
                  end
               end
            end
            RS_HOLD: begin
               if (rxd) st <= RS_IDLE;
            end
            default: st <= RS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 12,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [W-1:0]  wdata,
   input  logic          rd,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty,
   output logic          accepted
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("urx_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp;
   logic [AW-1:0] rp;
   logic          do_rd;

   assign full     = (count == CW'(DEPTH));
   assign empty    = (count == '0);
   assign accepted = wr && !full;
   assign do_rd    = rd && !empty;
   assign head     = mem[rp];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (accepted) begin
         mem[wp] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (accepted) wp <= wp + AW'(1);
         if (do_rd)    rp <= rp + AW'(1);
         case ({accepted, do_rd})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/urx_top.sv
module urx_top
   import urx_pkg::*;
#(
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned FIFO_DEPTH  = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned THR_W       = $clog2(FIFO_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [1:0]       cfg_fmt,
   input  logic             cfg_two_stop,
   input  logic             cfg_addr_en,
   input  logic             cfg_loop,
   input  logic [THR_W-1:0] cfg_irq_thr,
   input  logic             rx_pin,
   input  logic             tx_loop,
   input  logic             rd_en,
   input  logic             ovr_clr,
   output logic [8:0]       rd_data,
   output logic             rd_ferr,
   output logic             rd_perr,
   output logic             rd_is_addr,
   output logic             data_avail,
   output logic             rx_idle,
   output logic             overrun,
   output logic             irq
);
   localparam int unsigned CW    = $clog2(FIFO_DEPTH) + 1;
   localparam int unsigned ENT_W = $bits(urx_entry_t);

   if (THR_W != $clog2(FIFO_DEPTH)) begin : g_bad_thr
      $error("urx_top: THR_W must equal clog2(FIFO_DEPTH)");
   end

   logic          line_in;
   logic          rxd;
   logic          tick;
   logic          frm_valid;
   urx_entry_t    frm_entry;
   urx_entry_t    head_entry;
   logic [CW-1:0] fifo_cnt;
   logic          fifo_full;
   logic          fifo_empty;
   logic          fifo_acc;
   logic          addr_eff;
   logic          new_is_addr;

   assign line_in = cfg_loop ? tx_loop : rx_pin;

   urx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (line_in),
      .q     (rxd)
   );

   urx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk   (clk),
      .rst_n (rst_n),
      .div   (cfg_div),
      .tick  (tick)
   );

   urx_frame u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .rxd       (rxd),
      .fmt       (cfg_fmt),
      .two_stop  (cfg_two_stop),
      .addr_en   (cfg_addr_en),
      .out_valid (frm_valid),
      .out_entry (frm_entry),
      .idle      (rx_idle)
   );

   urx_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (frm_valid),
      .wdata    (frm_entry),
      .rd       (rd_en),
      .head     (head_entry),
      .count    (fifo_cnt),
      .full     (fifo_full),
      .empty    (fifo_empty),
      .accepted (fifo_acc)
   );

   assign rd_data     = head_entry.data;
   assign rd_ferr     = head_entry.ferr;
   assign rd_perr     = head_entry.perr;
   assign rd_is_addr  = head_entry.is_addr;
   assign data_avail  = !fifo_empty;
   assign addr_eff    = cfg_addr_en && (urx_fmt_e'(cfg_fmt) == FMT_9N);
   assign new_is_addr = frm_entry.is_addr;
   assign irq = fifo_acc && (addr_eff ? new_is_addr : (fifo_cnt >= CW'(cfg_irq_thr)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      overrun <= 1'b0;
      else if (frm_valid && fifo_full) overrun <= 1'b1;
      else if (ovr_clr)                overrun <= 1'b0;
   end
endmodule

// File: rtl/urx_chk.sv
module urx_chk #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned CW    = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          irq,
   input logic          store,
   input logic [CW-1:0] cnt,
   input logic          data_avail,
   input logic          rx_idle,
   input logic          overrun,
   input logic          ovr_clr,
   input logic          rd_en,
   input logic          addr_eff,
   input logic          store_addr
);
   localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

   assert_fifo_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL_C);

   assert_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && data_avail && !store |=> cnt == $past(cnt) - CW'(1));

   assert_ovr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !ovr_clr |=> overrun);

   assert_ovr_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(cnt) == FULL_C);

   assert_irq_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> store);

   assert_addr_irq_R12: assert property (@(posedge clk) disable iff (!rst_n)
      store && addr_eff && store_addr |-> irq);

   assert_avail_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_avail) |-> rx_idle);
endmodule

bind urx_top urx_chk #(
   .DEPTH (FIFO_DEPTH),
   .CW    ($clog2(FIFO_DEPTH) + 1)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq        (irq),
   .store      (fifo_acc),
   .cnt        (fifo_cnt),
   .data_avail (data_avail),
   .rx_idle    (rx_idle),
   .overrun    (overrun),
   .ovr_clr    (ovr_clr),
   .rd_en      (rd_en),
   .addr_eff   (addr_eff),
   .store_addr (new_is_addr)
);

// File: tb/urx_top_tb_top.sv
module urx_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_div = 16'd0;
   logic [1:0]  cfg_fmt = 2'd0;
   logic        cfg_two_stop = 1'b0;
   logic        cfg_addr_en = 1'b0;
   logic        cfg_loop = 1'b0;
   logic [1:0]  cfg_irq_thr = 2'd0;
   logic        rx_pin = 1'b1;
   logic        tx_line = 1'b1;
   logic        rd_en = 1'b0;
   logic        ovr_clr = 1'b0;
   logic [8:0]  rd_data;
   logic        rd_ferr, rd_perr, rd_is_addr, data_avail, rx_idle, overrun, irq;

   int n_chk = 0;
   int n_bad = 0;
   int irq_seen = 0;
   logic use_loop = 1'b0;

   always #10ns clk = ~clk;

   urx_top dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_fmt(cfg_fmt),
      .cfg_two_stop(cfg_two_stop), .cfg_addr_en(cfg_addr_en), .cfg_loop(cfg_loop),
      .cfg_irq_thr(cfg_irq_thr), .rx_pin(rx_pin), .tx_loop(tx_line), .rd_en(rd_en),
      .ovr_clr(ovr_clr), .rd_data(rd_data), .rd_ferr(rd_ferr), .rd_perr(rd_perr),
      .rd_is_addr(rd_is_addr), .data_avail(data_avail), .rx_idle(rx_idle),
      .overrun(overrun), .irq(irq)
   );

   always @(negedge clk) if (irq) irq_seen <= irq_seen + 1;

   // frame vectors: format, stop count, bits on the wire (bit 8 = parity or ninth bit),
   // stop samples, expected data / framing error / parity error
   typedef struct packed {
      logic [1:0] fmt;
      logic       two;
      logic [8:0] bits;
      logic       s1;
      logic       s2;
      logic [8:0] xd;
      logic       xf;
      logic       xp;
   } vec_t;

   // R2 plain byte, R3 even/odd good and bad parity, R4 nine bits, R5 stop errors
   localparam vec_t VECS [10] = '{
      '{2'd0, 1'b0, 9'h0A5, 1'b1, 1'b1, 9'h0A5, 1'b0, 1'b0},
      '{2'd1, 1'b0, 9'h137, 1'b1, 1'b1, 9'h037, 1'b0, 1'b0},
      '{2'd1, 1'b0, 9'h037, 1'b1, 1'b1, 9'h037, 1'b0, 1'b1},
      '{2'd2, 1'b0, 9'h037, 1'b1, 1'b1, 9'h037, 1'b0, 1'b0},
      '{2'd2, 1'b0, 9'h137, 1'b1, 1'b1, 9'h037, 1'b0, 1'b1},
      '{2'd3, 1'b0, 9'h1C3, 1'b1, 1'b1, 9'h1C3, 1'b0, 1'b0},
      '{2'd0, 1'b1, 9'h05A, 1'b1, 1'b0, 9'h05A, 1'b1, 1'b0},
      '{2'd0, 1'b0, 9'h0FF, 1'b0, 1'b1, 9'h0FF, 1'b1, 1'b0},
      '{2'd3, 1'b1, 9'h001, 1'b0, 1'b1, 9'h001, 1'b1, 1'b0},
      '{2'd1, 1'b1, 9'h101, 1'b1, 1'b1, 9'h001, 1'b0, 1'b0}
   };

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic v);
      if (use_loop) tx_line = v;
      else          rx_pin  = v;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hold(input int nbits);
      wait_cyc(nbits * 16 * (int'(cfg_div) + 1));
   endtask

   task automatic send(input logic [8:0] b, input logic s1, input logic s2);
      int nb;
      nb = (cfg_fmt == 2'd0) ? 8 : 9;
      drive(1'b0); hold(1);
      for (int i = 0; i < nb; i++) begin drive(b[i]); hold(1); end
      drive(s1); hold(1);
      if (cfg_two_stop) begin drive(s2); hold(1); end
      drive(1'b1); hold(2);
   endtask

   task automatic pop();
      rd_en = 1'b1; wait_cyc(1); rd_en = 1'b0; wait_cyc(1);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; wait_cyc(3); rst_n = 1'b1; wait_cyc(2);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=completion");
      summary();
      $finish;
   end

   initial begin
      int base;
      wait_cyc(3);
      // R14 reset state
      check("R14 idle", int'(rx_idle), 1);
      check("R14 avail", int'(data_avail), 0);
      check("R14 overrun", int'(overrun), 0);
      check("R14 irq", int'(irq), 0);
      check("R14 data", int'(rd_data), 0);
      rst_n = 1'b1; wait_cyc(4);

      // vector walk
      for (int k = 0; k < 10; k++) begin
         cfg_fmt = VECS[k].fmt; cfg_two_stop = VECS[k].two;
         send(VECS[k].bits, VECS[k].s1, VECS[k].s2);
         check($sformatf("R9 vec%0d avail", k), int'(data_avail), 1);
         check($sformatf("R2 R3 R4 vec%0d data", k), int'(rd_data), int'(VECS[k].xd));
         check($sformatf("R5 vec%0d ferr", k), int'(rd_ferr), int'(VECS[k].xf));
         check($sformatf("R3 vec%0d perr", k), int'(rd_perr), int'(VECS[k].xp));
         pop();
         check($sformatf("R9 vec%0d drained", k), int'(data_avail), 0);
      end
      cfg_two_stop = 1'b0; cfg_fmt = 2'd0;

      // R6 idle window
      drive(1'b0); hold(1);
      check("R6 idle low in frame", int'(rx_idle), 0);
      for (int i = 0; i < 8; i++) begin drive(1'b1); hold(1); end
      drive(1'b1); wait_cyc(2);
      check("R6 idle before stop centre", int'(rx_idle), 0);
      wait_cyc(14);
      check("R6 idle after stop centre", int'(rx_idle), 1);
      hold(2);
      check("R6 word", int'(rd_data), 'hFF);
      pop();

      // R7 false start
      drive(1'b0); wait_cyc(4); drive(1'b1); hold(3);
      check("R7 no word", int'(data_avail), 0);
      check("R7 idle", int'(rx_idle), 1);

      // R8 break in odd parity mode
      cfg_fmt = 2'd2;
      drive(1'b0); hold(12);
      check("R8 break stored", int'(data_avail), 1);
      check("R8 break data", int'(rd_data), 0);
      check("R8 break ferr", int'(rd_ferr), 1);
      check("R8 break perr", int'(rd_perr), 0);
      check("R8 break idle", int'(rx_idle), 1);
      pop();
      hold(28);
      check("R8 no restart while low", int'(data_avail), 0);
      drive(1'b1); hold(2);
      send(9'h13C, 1'b1, 1'b1);
      check("R8 after release data", int'(rd_data), 'h03C);
      check("R8 after release ferr", int'(rd_ferr), 0);
      pop();
      cfg_fmt = 2'd0;

      // R9 ordering, R10 overrun, R11 threshold zero
      cfg_irq_thr = 2'd0;
      base = irq_seen;
      send(9'h011, 1'b1, 1'b1); send(9'h022, 1'b1, 1'b1);
      send(9'h033, 1'b1, 1'b1); send(9'h044, 1'b1, 1'b1);
      check("R10 no overrun at full", int'(overrun), 0);
      send(9'h055, 1'b1, 1'b1);
      check("R10 overrun set", int'(overrun), 1);
      check("R11 irq per stored word", irq_seen - base, 4);
      hold(2);
      check("R10 overrun sticky", int'(overrun), 1);
      check("R9 head 1", int'(rd_data), 'h011); pop();
      check("R9 head 2", int'(rd_data), 'h022); pop();
      check("R9 head 3", int'(rd_data), 'h033); pop();
      check("R9 head 4", int'(rd_data), 'h044); pop();
      check("R10 fifth dropped", int'(data_avail), 0);
      ovr_clr = 1'b1; wait_cyc(1); ovr_clr = 1'b0; wait_cyc(1);
      check("R10 overrun cleared", int'(overrun), 0);

      // R11 threshold two
      cfg_irq_thr = 2'd2;
      base = irq_seen;
      send(9'h0A1, 1'b1, 1'b1); send(9'h0A2, 1'b1, 1'b1); send(9'h0A3, 1'b1, 1'b1);
      check("R11 irq at threshold", irq_seen - base, 1);
      pop(); pop(); pop();

      // R12 address tagging
      cfg_fmt = 2'd3; cfg_addr_en = 1'b1; cfg_irq_thr = 2'd3;
      base = irq_seen;
      send(9'h105, 1'b1, 1'b1); send(9'h022, 1'b1, 1'b1); send(9'h1FE, 1'b1, 1'b1);
      check("R12 irq per address", irq_seen - base, 2);
      check("R12 tag 1", int'(rd_is_addr), 1); pop();
      check("R12 tag 2", int'(rd_is_addr), 0); pop();
      check("R12 tag 3", int'(rd_is_addr), 1); pop();
      cfg_fmt = 2'd0;
      send(9'h080, 1'b1, 1'b1);
      check("R12 no tag in 8-bit", int'(rd_is_addr), 0);
      pop();
      cfg_addr_en = 1'b0; cfg_irq_thr = 2'd0;

      // R13 loopback
      tx_line = 1'b1; cfg_loop = 1'b1; use_loop = 1'b1; rx_pin = 1'b0;
      wait_cyc(4);
      send(9'h096, 1'b1, 1'b1);
      check("R13 loop data", int'(rd_data), 'h096);
      check("R13 loop ferr", int'(rd_ferr), 0);
      pop();
      for (int i = 0; i < 6; i++) begin rx_pin = ~rx_pin; hold(2); end
      check("R13 pin ignored", int'(data_avail), 0);
      rx_pin = 1'b1; use_loop = 1'b0; cfg_loop = 1'b0; wait_cyc(4);

      // R1 slower divider
      cfg_div = 16'd2; hold(1);
      send(9'h0C3, 1'b1, 1'b1);
      check("R1 divided data", int'(rd_data), 'h0C3);
      check("R1 divided ferr", int'(rd_ferr), 0);
      pop();
      cfg_div = 16'd0; hold(1);

      // R14 reset clears queue and overrun
      send(9'h001, 1'b1, 1'b1);
      do_reset();
      check("R14 queue cleared", int'(data_avail), 0);
      check("R14 data cleared", int'(rd_data), 0);

      summary();
      $finish;
   end
endmodule